// File: doc/BRIEF.md
# Chunked Firmware Download Engine with CRC-16 Check

This block takes a firmware image from a host over a byte-wide register bus and hands each byte to an on-chip program RAM through a write port. While the image loads, it holds an embedded microcontroller in reset. The image arrives in chunks of 0 to 255 payload bytes.

For each chunk, the host first writes a payload byte count. It then writes a three-byte start sequence: address high byte, address low byte, and the control code 0x81. After that it streams the payload through a single data port, followed by two CRC bytes through the same port. The engine separates the CRC bytes from the payload using the declared count. It runs a CRC-16 over the payload and records in a status register whether the received checksum matches.

Any register read after the CRC closes the chunk. A write of bit 7 to the transfer register holds the microcontroller in reset. If that write comes after a CRC has been received, it also marks the transfer complete. The program RAM base is 0x1000 or 0x0000, chosen by a configuration pin that can be read back.

Top module: `fw_loader`

## Requirements
- R1: After reset the status register (offset 0x14) reads 0x00, `mcu_reset` is low and `ram_we` is low.
- R2: A chunk is armed only by three consecutive writes to offset 0x10 (address high, address low, control byte 0x81). A different control byte leaves no chunk open (status bit 4 = 0), and later data writes (offset 0x11) cause no RAM write.
- R3: The RAM index of the first payload byte equals the start address minus the base, taken modulo 2^13. The base is 0x1000 when `cfg_hi_base` is 1 and 0x0000 otherwise. Offset 0x15 reads 0x10 when `cfg_hi_base` is 1.
- R4: Each payload byte written to offset 0x11 gives one `ram_we` pulse in the following cycle. The RAM index increments after every byte and wraps from 0x1FFF to 0x0000.
- R5: The payload count written to offset 0x12 (0 to 255) sets the number of data bytes stored. The next two data writes after the payload are the CRC (high byte, then low byte), and they write nothing to RAM.
- R6: The CRC is polynomial 0x1021, processed MSB first, initial value 0x0000, and restarted for every chunk. For example, the ASCII bytes "123456789" give 0x31C3. After the CRC low byte, status bit 0 reads 1 and status bit 1 reads 1 only on a match.
- R7: Arming a chunk clears status bits 0 (CRC received), 1 (CRC ok) and 2 (complete), and sets bit 4 (chunk open).
- R8: Any register read after the CRC low byte closes the chunk, so bit 4 reads 0 from the next cycle. Data writes to a received or closed chunk are ignored.
- R9: A write to offset 0x13 with bit 7 set drives `mcu_reset` high (status bit 3). A write with bit 7 clear releases it and clears status bit 2.
- R10: A write of bit 7 to offset 0x13 sets status bit 2 only if a CRC has been received since the last arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hi_base | input | 1 | Selects RAM base 0x1000 (1) or 0x0000 (0) |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_rd | input | 1 | Register read strobe, one cycle per byte |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ram_we | output | 1 | Program RAM write enable |
| ram_addr | output | 13 | Program RAM byte index |
| ram_wdata | output | 8 | Program RAM write data |
| mcu_reset | output | 1 | Holds the microcontroller in reset |

## Verification
Most internal faults surface on the RAM write port within one cycle of the data write that triggers them. A miscounted payload counter stores a CRC byte in RAM, or drops the last payload byte, and the scoreboard catches it as an unexpected or missing write. A wrong pointer or base offset shows up as a bad address on the first byte of the chunk. A CRC engine fault stays hidden until the CRC low byte, and then appears in the status register. To catch it at that point, the bench uses one chunk with a known checksum, one with a deliberately corrupted checksum, and checksums computed bit-serially. Sequencer faults in the open, close and complete steps show up on the status read right after the write or read that should change them.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  localparam logic [7:0] REG_START  = 8'h10;
  localparam logic [7:0] REG_DATA   = 8'h11;
  localparam logic [7:0] REG_COUNT  = 8'h12;
  localparam logic [7:0] REG_XFER   = 8'h13;
  localparam logic [7:0] REG_STATUS = 8'h14;
  localparam logic [7:0] REG_IDENT  = 8'h15;

  localparam logic [7:0] ARM_CODE = 8'h81;
  localparam int HOLD_BIT = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_CRC_HI,
    PH_CRC_LO,
    PH_DONE
  } phase_t;

  // One byte folded into the running CRC, high bit first.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] acc,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = acc ^ {b, {(CRC_W-BYTE_W){1'b0}}};
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[CRC_W-1]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else            r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/fwl_regdec.sv
module fwl_regdec
  import fwl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic        arm,
  output logic [15:0] arm_addr,
  output logic        data_stb,
  output logic        count_stb,
  output logic        xfer_stb,
  output logic        rd_stb
);
  logic [1:0] seq_idx;
  logic [7:0] hi_q, lo_q;
  logic       wr_start;

  assign wr_start  = bus_wr && (bus_addr == REG_START);
  assign data_stb  = bus_wr && (bus_addr == REG_DATA);
  assign count_stb = bus_wr && (bus_addr == REG_COUNT);
  assign xfer_stb  = bus_wr && (bus_addr == REG_XFER);
  assign rd_stb    = bus_rd;

  assign arm      = wr_start && (seq_idx == 2'd2) && (bus_wdata == ARM_CODE);
  assign arm_addr = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_idx <= 2'd0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (wr_start) begin
      case (seq_idx)
        2'd0: begin hi_q <= bus_wdata; seq_idx <= 2'd1; end
        2'd1: begin lo_q <= bus_wdata; seq_idx <= 2'd2; end
        default: seq_idx <= 2'd0;
      endcase
    end else if (bus_wr || bus_rd) begin
      seq_idx <= 2'd0;
    end
  end
endmodule

// File: rtl/fwl_crc16.sv
module fwl_crc16
  import fwl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (upd) crc <= crc_fold(crc, din);
  end
endmodule

// File: rtl/fwl_seq.sv
module fwl_seq
  import fwl_pkg::*;
#(
  parameter int RAM_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [RAM_AW-1:0] arm_index,
  input  logic [7:0]        count,
  input  logic              data_stb,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              rd_stb,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ev_payload,
  output logic              ev_crc_lo,
  output logic              ev_close,
  output logic [CRC_W-1:0]  rx_crc,
  output logic              chunk_open
);
  phase_t            ph;
  logic [RAM_AW-1:0] ptr;
  logic [7:0]        left;
  logic [7:0]        rx_hi;

  assign ev_payload = data_stb && (ph == PH_LOAD);
  assign ev_crc_lo  = data_stb && (ph == PH_CRC_LO);
  assign ev_close   = rd_stb && (ph == PH_DONE);
  assign rx_crc     = {rx_hi, data_byte};
  assign chunk_open = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= ev_payload;
      if (ev_payload) begin
        ram_addr  <= ptr;
        ram_wdata <= data_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      ptr   <= '0;
      left  <= '0;
      rx_hi <= '0;
    end else if (arm) begin
      ptr  <= arm_index;
      left <= count;
      ph   <= (count == 8'd0) ? PH_CRC_HI : PH_LOAD;
    end else begin
      case (ph)
        PH_LOAD: if (data_stb) begin
          ptr  <= ptr + 1'b1;
          left <= left - 8'd1;
          if (left == 8'd1) ph <= PH_CRC_HI;
        end
        PH_CRC_HI: if (data_stb) begin
          rx_hi <= data_byte;
          ph    <= PH_CRC_LO;
        end
        PH_CRC_LO: if (data_stb) ph <= PH_DONE;
        PH_DONE:   if (rd_stb)   ph <= PH_IDLE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fw_loader.sv
module fw_loader
  import fwl_pkg::*;
#(
  parameter int          RAM_AW  = 13,
  parameter logic [15:0] HI_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hi_base,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              mcu_reset
);
  logic              ev_arm, data_stb, count_stb, xfer_stb, rd_stb;
  logic [15:0]       arm_addr, base_addr, arm_off;
  logic [RAM_AW-1:0] arm_index;
  logic [7:0]        count_q;
  logic              ev_payload, ev_crc_lo, ev_close, chunk_open;
  logic [CRC_W-1:0]  rx_crc, crc_val;
  logic              crc_rcvd, crc_ok, xfer_done;

  fwl_regdec u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .arm(ev_arm), .arm_addr(arm_addr), .data_stb(data_stb),
    .count_stb(count_stb), .xfer_stb(xfer_stb), .rd_stb(rd_stb)
  );

  assign base_addr = cfg_hi_base ? HI_BASE : 16'h0000;
  assign arm_off   = arm_addr - base_addr;
  assign arm_index = arm_off[RAM_AW-1:0];

  fwl_seq #(.RAM_AW(RAM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(ev_arm), .arm_index(arm_index),
    .count(count_q), .data_stb(data_stb), .data_byte(bus_wdata),
    .rd_stb(rd_stb), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ev_payload(ev_payload), .ev_crc_lo(ev_crc_lo),
    .ev_close(ev_close), .rx_crc(rx_crc), .chunk_open(chunk_open)
  );

  fwl_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(ev_arm), .upd(ev_payload),
    .din(bus_wdata), .crc(crc_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      crc_rcvd  <= 1'b0;
      crc_ok    <= 1'b0;
      xfer_done <= 1'b0;
      mcu_reset <= 1'b0;
    end else begin
      if (count_stb) count_q <= bus_wdata;
      if (ev_arm) begin
        crc_rcvd  <= 1'b0;
        crc_ok    <= 1'b0;
        xfer_done <= 1'b0;
      end else if (ev_crc_lo) begin
        crc_rcvd <= 1'b1;
        crc_ok   <= (rx_crc == crc_val);
      end
      if (xfer_stb) begin
        mcu_reset <= bus_wdata[HOLD_BIT];
        xfer_done <= bus_wdata[HOLD_BIT] && crc_rcvd;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      REG_STATUS: bus_rdata = {3'b000, chunk_open, mcu_reset, xfer_done, crc_ok, crc_rcvd};
      REG_COUNT:  bus_rdata = count_q;
      REG_IDENT:  bus_rdata = {3'b000, cfg_hi_base, 4'h0};
      default:    bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/fwl_chk.sv
module fwl_chk
  import fwl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [7:0] bus_addr,
  input logic       ram_we,
  input logic       ev_arm,
  input logic       ev_payload,
  input logic       ev_crc_lo,
  input logic       ev_close,
  input logic       chunk_open,
  input logic       crc_rcvd,
  input logic       crc_ok,
  input logic       xfer_done,
  input logic       mcu_reset
);
  // R4
  ram_we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(bus_wr && (bus_addr == REG_DATA)));
  // R4
  payload_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_payload |=> ram_we);
  // R5
  crc_byte_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc_lo |=> !ram_we);
  // R6
  ok_implies_rcvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> crc_rcvd);
  // R7
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |=> (chunk_open && !crc_rcvd && !crc_ok && !xfer_done));
  // R8
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> !chunk_open);
  // R10
  done_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (mcu_reset && crc_rcvd));
endmodule

bind fw_loader fwl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ram_we(ram_we), .ev_arm(ev_arm), .ev_payload(ev_payload),
  .ev_crc_lo(ev_crc_lo), .ev_close(ev_close), .chunk_open(chunk_open),
  .crc_rcvd(crc_rcvd), .crc_ok(crc_ok), .xfer_done(xfer_done),
  .mcu_reset(mcu_reset)
);

// File: tb/fw_loader_tb.sv
module fw_loader_tb;
  localparam logic [7:0] A_START = 8'h10, A_DATA = 8'h11, A_COUNT = 8'h12,
                         A_XFER = 8'h13, A_STAT = 8'h14, A_IDENT = 8'h15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_hi_base = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        mcu_reset;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [20:0] exp_q[$];
  logic [7:0]  pay[256];

  always #2.5 clk = ~clk;

  fw_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_hi_base(cfg_hi_base),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .mcu_reset(mcu_reset)
  );

  // Bit-serial CRC model: feedback bit is the top bit xor the incoming bit.
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        logic fb;
        fb = c[15] ^ pay[k][i];
        c = c << 1;
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic arm_chunk(input logic [15:0] start, input int n);
    wr(A_COUNT, 8'(n));
    wr(A_START, start[15:8]);
    wr(A_START, start[7:0]);
    wr(A_START, 8'h81);
  endtask

  // Driver: pushes the expected RAM writes, then streams payload and CRC.
  task automatic feed_chunk(input logic [15:0] start, input int n, input logic [15:0] crc);
    logic [15:0] base;
    logic [15:0] idx;
    base = cfg_hi_base ? 16'h1000 : 16'h0000;
    idx  = start - base;
    for (int k = 0; k < n; k++) begin
      logic [12:0] a;
      a = 13'(idx[12:0] + 13'(k));
      exp_q.push_back({a, pay[k]});
      wr(A_DATA, pay[k]);
    end
    wr(A_DATA, crc[15:8]);
    wr(A_DATA, crc[7:0]);
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int k = 0; k < 256; k++) pay[k] = 8'(seed + 8'(k * 13) ^ 8'(k >> 3));
  endtask

  // Monitor: every RAM write must match the head of the expected queue.
  always @(negedge clk) begin
    if (rst_n && ram_we === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4/R5 unexpected RAM write actual %h expected none", {ram_addr, ram_wdata});
      end else begin
        logic [20:0] e;
        e = exp_q.pop_front();
        chk("R4 RAM write addr/data", {ram_addr, ram_wdata}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STAT, s);  chk("R1 status", s, 8'h00);
    chk("R1 ram_we/mcu_reset", {ram_we, mcu_reset}, 2'b00);

    // R3 identity bit
    rd(A_IDENT, s); chk("R3 ident", s, 8'h10);

    // R9 hold
    wr(A_XFER, 8'h80);
    rd(A_STAT, s);  chk("R9 hold set", s, 8'h08);

    // R6 known vector, R3 base 0x1000 -> index 0
    pay[0] = 8'h31; pay[1] = 8'h32; pay[2] = 8'h33; pay[3] = 8'h34; pay[4] = 8'h35;
    pay[5] = 8'h36; pay[6] = 8'h37; pay[7] = 8'h38; pay[8] = 8'h39;
    arm_chunk(16'h1000, 9);
    feed_chunk(16'h1000, 9, 16'h31C3);
    rd(A_STAT, s);  chk("R6 known CRC pass, open", s, 8'h1B);
    rd(A_STAT, s);  chk("R8 chunk closed by read", s, 8'h0B);
    wr(A_DATA, 8'h55);
    repeat (2) @(negedge clk);
    chk("R8 no pending RAM writes", 21'(exp_q.size()), 21'd0);

    // R10 complete after CRC
    wr(A_XFER, 8'h80);
    rd(A_STAT, s);  chk("R10 complete", s, 8'h0F);

    // R7 arm clears, R6 mismatch
    fill(8'h5A);
    arm_chunk(16'h1100, 3);
    rd(A_STAT, s);  chk("R7 arm clears status", s, 8'h18);
    feed_chunk(16'h1100, 3, ref_crc(3) ^ 16'h0001);
    rd(A_STAT, s);  chk("R6 bad CRC flagged", s, 8'h19);
    rd(A_STAT, s);  chk("R8 closed after bad CRC", s, 8'h09);

    // R4 wrap 0x1FFF -> 0x0000
    fill(8'h3C);
    arm_chunk(16'h2FFE, 4);
    feed_chunk(16'h2FFE, 4, ref_crc(4));
    rd(A_STAT, s);  chk("R4 wrap chunk CRC ok", s, 8'h1B);

    // R2 bad control byte
    wr(A_START, 8'h10); wr(A_START, 8'h00); wr(A_START, 8'h80);
    rd(A_STAT, s);  chk("R2 no chunk opened", s, 8'h0B);
    wr(A_DATA, 8'hAA);
    repeat (2) @(negedge clk);
    chk("R2 no RAM write", 21'(exp_q.size()), 21'd0);

    // R5 full 255-byte chunk, R3 base 0
    cfg_hi_base = 1'b0;
    rd(A_IDENT, s); chk("R3 ident low base", s, 8'h00);
    fill(8'h91);
    arm_chunk(16'h0100, 255);
    feed_chunk(16'h0100, 255, ref_crc(255));
    rd(A_STAT, s);  chk("R5 255-byte chunk CRC ok", s, 8'h1B);

    // R5 empty chunk: CRC of nothing is 0
    arm_chunk(16'h0200, 0);
    feed_chunk(16'h0200, 0, 16'h0000);
    rd(A_STAT, s);  chk("R5 zero-count chunk", s, 8'h1B);

    // R9 release
    wr(A_XFER, 8'h00);
    rd(A_STAT, s);  chk("R9 hold released", s, 8'h03);
    chk("R9 mcu_reset pin", mcu_reset, 1'b0);

    // R10 no complete without CRC
    arm_chunk(16'h0300, 2);
    wr(A_XFER, 8'h80);
    rd(A_STAT, s);  chk("R10 complete needs CRC", s, 8'h18);

    repeat (4) @(negedge clk);
    chk("R4 scoreboard drained", 21'(exp_q.size()), 21'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule